// File: doc/BRIEF.md
# Per-Timeslot Transmit Routing Table

This block steers the bits of a framed PCM transmit stream into up to three transmit channel buffers. A programmable table holds one entry per timeslot. Each entry picks where the slot's bits come from and which channels receive them. The four sources are the serial PCM input, a separate insert-data input, a test pattern generator, or a repeat of the slot before. The destination set may be empty, a single channel, a pair of channels, or all three, so one slot can be copied to several channels at once.

Timing comes from outside the block. An external counter supplies the current slot index, a bit strobe for every PCM bit, and a marker on the last bit of each slot. Slot 0 is the framing-bit position and is one bit long. Every other slot carries eight bits, sent MSB first.

For every strobed bit the block does three things:
- It drives the chosen data bit to the channel buffers.
- It pulses the write strobe of each selected channel.
- It raises a marker towards the insert-data source or an enable towards the pattern generator, according to the slot's entry.

Table writes go to a shadow copy. The shadow copy becomes active only when a frame ends.

Top module: `tx_slot_router`

## Requirements
- R1: The table has one entry per timeslot, including the one-bit framing slot 0. An entry is written with `cfg_we` high, `cfg_addr` set to the slot index and `cfg_data`, whose bits [2:0] are the destination mask (bit c selects channel c) and whose bits [4:3] are the source code.
- R2: Source code 0 selects `pcm_din`, code 1 selects `ins_din`, code 2 selects `pat_din` and code 3 selects the repeat value. The selected bit, sampled at the strobe edge, appears on `ch_dat`.
- R3: In a slot whose source is not code 1, each set mask bit c pulses `ch_wr[c]` for one cycle, one clock after each bit strobe of that slot, while `ch_dat` carries the bit. A slot with an empty mask produces no write strobe.
- R4: In a code-3 slot, bit k (k = 0 is the first bit) equals bit 7-k of the last eight data-path bits assembled before the slot began, oldest in bit 7, whatever their sources were. Consecutive code-3 slots therefore repeat the same byte.
- R5: In a code-1 slot, `ins_mark` is high in the same cycle as each bit strobe, and `ins_din` is sampled at that clock edge.
- R6: Bits taken in a code-1 slot only enter the repeat history. That entry's mask is ignored and no write strobe is issued. A following code-3 slot routes those bits under its own mask.
- R7: `pat_en` is high in the cycle of a bit strobe only when the slot's source is code 2. It is never high together with `ins_mark`.
- R8: A table write changes nothing in the frame in progress. All writes take effect together after the strobe carrying `slot_end` in the last slot.
- R9: After reset every entry is source 0 with an empty mask, the repeat history is zero, and `ch_wr`, `ins_mark` and `pat_en` are low.
- R10: In a cycle without a bit strobe, the next cycle carries no write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table entry write enable |
| cfg_addr | input | 5 | Slot index of the entry written |
| cfg_data | input | 5 | Entry: [4:3] source code, [2:0] destination mask |
| slot_num | input | 5 | Current timeslot index |
| slot_end | input | 1 | Current strobed bit is the last of its slot |
| bit_stb | input | 1 | One PCM bit is present this cycle |
| pcm_din | input | 1 | Serial PCM data bit |
| ins_din | input | 1 | Insert-data bit |
| pat_din | input | 1 | Test pattern generator bit |
| ins_mark | output | 1 | Insert-data sampling marker |
| pat_en | output | 1 | Advance enable for the pattern generator |
| ch_wr | output | 3 | Per-channel write strobes |
| ch_dat | output | 1 | Data bit for the strobed channels |

## Verification
`ins_mark` and `pat_en` follow the strobe within the same cycle. The bench therefore reads them shortly after it drives a strobed bit, before the clock edge. `ch_wr` and `ch_dat` come from one register stage, so they are read on the falling edge that follows the strobe's rising edge.

The bench loads a new table during a frame. Its expected results keep using the old table until the strobe with `slot_end` in the last slot, and the new table from the next bit on. Repeat bits are predicted from the bench's own eight-bit history of the expected data bits.

// File: rtl/txr_pkg.sv
package txr_pkg;
  typedef enum logic [1:0] {
    SRC_PCM = 2'd0,
    SRC_INS = 2'd1,
    SRC_PAT = 2'd2,
    SRC_REP = 2'd3
  } src_e;

  localparam int unsigned HIST_W = 8;
endpackage

// File: rtl/txr_table.sv
module txr_table #(
  parameter int unsigned NUM_SLOTS = 25,
  parameter int unsigned NUM_CH    = 3,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS),
  localparam int unsigned ENT_W    = NUM_CH + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_addr,
  input  logic [ENT_W-1:0]  wr_data,
  input  logic              swap,
  input  logic [SLOT_W-1:0] rd_addr,
  output logic [ENT_W-1:0]  rd_ent
);
  logic [NUM_SLOTS-1:0][ENT_W-1:0] shd_q, shd_d;
  logic [NUM_SLOTS-1:0][ENT_W-1:0] act_q, act_d;

  // shadow copy takes register writes at any time
  always_comb begin
    shd_d = shd_q;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (wr_en && (32'(wr_addr) == i)) shd_d[i] = wr_data;
    end
  end

  // active copy changes only at the frame boundary
  always_comb begin
    act_d = act_q;
    if (swap) act_d = shd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q <= '0;
      act_q <= '0;
    end else begin
      shd_q <= shd_d;
      act_q <= act_d;
    end
  end

  always_comb begin
    rd_ent = '0;
    if (32'(rd_addr) < NUM_SLOTS) rd_ent = act_q[rd_addr];
  end

  // R8: active table frozen between frame boundaries
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !swap |=> $stable(act_q));
  // R8: a boundary loads exactly what the shadow held
  a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> act_q == $past(shd_q));
endmodule

// File: rtl/txr_slot_trk.sv
module txr_slot_trk #(
  parameter int unsigned NUM_SLOTS = 25,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              slot_end,
  input  logic [SLOT_W-1:0] slot_num,
  output logic [2:0]        bit_pos,
  output logic              frame_end
);
  logic [2:0] pos_q, pos_d;

  always_comb begin
    pos_d = pos_q;
    if (bit_stb) pos_d = slot_end ? 3'd0 : pos_q + 3'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= 3'd0;
    else        pos_q <= pos_d;
  end

  assign bit_pos   = pos_q;
  assign frame_end = bit_stb && slot_end && (32'(slot_num) == NUM_SLOTS - 1);

  // R4: bit position only moves on a strobe
  a_r4_pos_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> $stable(bit_pos));
  // R4: each slot begins at bit 0
  a_r4_pos_start: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && slot_end) |=> bit_pos == 3'd0);
endmodule

// File: rtl/txr_datapath.sv
module txr_datapath
  import txr_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  localparam int unsigned ENT_W = NUM_CH + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              slot_end,
  input  logic [ENT_W-1:0]  ent,
  input  logic [2:0]        bit_pos,
  input  logic              pcm_din,
  input  logic              ins_din,
  input  logic              pat_din,
  output logic              ins_mark,
  output logic              pat_en,
  output logic [NUM_CH-1:0] ch_wr,
  output logic              ch_dat
);
  src_e              src;
  logic [NUM_CH-1:0] mask;
  logic              sel_bit;
  logic [HIST_W-1:0] hist_q, hist_d;
  logic [HIST_W-1:0] snap_q, snap_d;
  logic [NUM_CH-1:0] wr_q, wr_d;
  logic              dat_q, dat_d;

  assign src  = src_e'(ent[ENT_W-1 -: 2]);
  assign mask = ent[NUM_CH-1:0];

  always_comb begin
    unique case (src)
      SRC_PCM: sel_bit = pcm_din;
      SRC_INS: sel_bit = ins_din;
      SRC_PAT: sel_bit = pat_din;
      default: sel_bit = snap_q[3'd7 - bit_pos];
    endcase
  end

  assign ins_mark = bit_stb && (src == SRC_INS);
  assign pat_en   = bit_stb && (src == SRC_PAT);

  // running history of every bit on the path; snapshot at slot end
  always_comb begin
    hist_d = hist_q;
    snap_d = snap_q;
    dat_d  = dat_q;
    if (bit_stb) begin
      hist_d = {hist_q[HIST_W-2:0], sel_bit};
      dat_d  = sel_bit;
      if (slot_end) snap_d = hist_d;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_strobe
    assign wr_d[c] = bit_stb && (src != SRC_INS) && mask[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      snap_q <= '0;
      wr_q   <= '0;
      dat_q  <= 1'b0;
    end else begin
      hist_q <= hist_d;
      snap_q <= snap_d;
      wr_q   <= wr_d;
      dat_q  <= dat_d;
    end
  end

  assign ch_wr  = wr_q;
  assign ch_dat = dat_q;

  // R7: generator enable and insert marker never overlap
  a_r7_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ins_mark, pat_en}));
  // R6: an insert slot writes to no channel
  a_r6_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    ins_mark |=> ch_wr == '0);
  // R10: no strobe in, no write out
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> ch_wr == '0);
  // R3: writes stay inside the entry's destination mask
  a_r3_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> (ch_wr & ~$past(mask)) == '0);
endmodule

// File: rtl/tx_slot_router.sv
module tx_slot_router
  import txr_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 25,
  parameter int unsigned NUM_CH    = 3,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS),
  localparam int unsigned ENT_W    = NUM_CH + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SLOT_W-1:0] cfg_addr,
  input  logic [ENT_W-1:0]  cfg_data,
  input  logic [SLOT_W-1:0] slot_num,
  input  logic              slot_end,
  input  logic              bit_stb,
  input  logic              pcm_din,
  input  logic              ins_din,
  input  logic              pat_din,
  output logic              ins_mark,
  output logic              pat_en,
  output logic [NUM_CH-1:0] ch_wr,
  output logic              ch_dat
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic [ENT_W-1:0] cur_ent;
  logic [2:0]       bit_pos;
  logic             frame_end;

  // reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  txr_table #(.NUM_SLOTS(NUM_SLOTS), .NUM_CH(NUM_CH)) u_table (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (cfg_we),
    .wr_addr (cfg_addr),
    .wr_data (cfg_data),
    .swap    (frame_end),
    .rd_addr (slot_num),
    .rd_ent  (cur_ent)
  );

  txr_slot_trk #(.NUM_SLOTS(NUM_SLOTS)) u_trk (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .bit_stb   (bit_stb),
    .slot_end  (slot_end),
    .slot_num  (slot_num),
    .bit_pos   (bit_pos),
    .frame_end (frame_end)
  );

  txr_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .bit_stb  (bit_stb),
    .slot_end (slot_end),
    .ent      (cur_ent),
    .bit_pos  (bit_pos),
    .pcm_din  (pcm_din),
    .ins_din  (ins_din),
    .pat_din  (pat_din),
    .ins_mark (ins_mark),
    .pat_en   (pat_en),
    .ch_wr    (ch_wr),
    .ch_dat   (ch_dat)
  );
endmodule

// File: tb/tx_slot_router_tb.sv
module tx_slot_router_tb;
  localparam int NS = 25;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [4:0] cfg_addr;
  logic [4:0] cfg_data;
  logic [4:0] slot_num;
  logic       slot_end, bit_stb, pcm_din, ins_din, pat_din;
  logic       ins_mark, pat_en, ch_dat;
  logic [2:0] ch_wr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [4:0]  m_act [NS];
  logic [4:0]  m_shd [NS];
  logic [7:0]  m_hist, m_snap;
  logic [31:0] rng;
  int          widx;
  string       phase;

  always #2 clk = ~clk;

  tx_slot_router u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .slot_num(slot_num), .slot_end(slot_end),
    .bit_stb(bit_stb), .pcm_din(pcm_din), .ins_din(ins_din),
    .pat_din(pat_din), .ins_mark(ins_mark), .pat_en(pat_en),
    .ch_wr(ch_wr), .ch_dat(ch_dat)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s]: actual %0h expected %0h", tag, phase, act, exp);
    end
  endtask

  // entry encoding per R1: {source[1:0], mask[2:0]}
  function automatic logic [4:0] tab(input int sel, input int s);
    logic [1:0] sr;
    logic [2:0] mk;
    case (sel)
      1: begin sr = 2'(s % 4);           mk = 3'((s / 4) % 8); end
      2: begin sr = 2'((s * 3 + 1) % 4); mk = 3'((s * 5 + 3) % 8); end
      default: begin
        case (s % 6)
          1: begin sr = 2'd1; mk = 3'd7; end
          2: begin sr = 2'd3; mk = 3'd5; end
          3: begin sr = 2'd3; mk = 3'd2; end
          4: begin sr = 2'd2; mk = 3'd1; end
          default: begin sr = 2'd0; mk = 3'd4; end
        endcase
      end
    endcase
    return {sr, mk};
  endfunction

  task automatic do_bit(input int s, input int k, input bit last, input int wsel);
    logic       pcm, ins, pat, b;
    logic [1:0] src;
    logic [2:0] msk, ewr;
    logic [4:0] e;
    bit         wrote;
    rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
    pcm = rng[0]; ins = rng[5]; pat = rng[9];
    e = m_act[s]; src = e[4:3]; msk = e[2:0];
    case (src)
      2'd0: b = pcm;
      2'd1: b = ins;
      2'd2: b = pat;
      default: b = m_snap[7 - k];
    endcase
    slot_num = 5'(s); slot_end = last; bit_stb = 1'b1;
    pcm_din = pcm; ins_din = ins; pat_din = pat;
    wrote = (wsel != 0) && (widx < NS);
    if (wrote) begin
      cfg_we = 1'b1; cfg_addr = 5'(widx); cfg_data = tab(wsel, widx);
    end else cfg_we = 1'b0;
    #1;
    chk({7'd0, ins_mark}, {7'd0, src == 2'd1}, "R5 ins_mark");
    chk({7'd0, pat_en}, {7'd0, src == 2'd2}, "R7 pat_en");
    @(posedge clk); @(negedge clk);
    ewr = (src == 2'd1) ? 3'd0 : msk;
    chk({5'd0, ch_wr}, {5'd0, ewr}, (src == 2'd1) ? "R6 ch_wr" : "R3 ch_wr");
    if (ewr != 3'd0)
      chk({7'd0, ch_dat}, {7'd0, b},
          (src == 2'd3) ? "R4 repeat" : (s == 0) ? "R1 framing slot" : "R2 ch_dat");
    m_hist = {m_hist[6:0], b};
    if (last) m_snap = m_hist;
    if (s == NS - 1 && last) begin
      for (int i = 0; i < NS; i++) m_act[i] = m_shd[i];
    end
    if (wrote) begin
      m_shd[widx] = tab(wsel, widx);
      widx++;
    end
    bit_stb = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic run_frame(input int wsel);
    widx = 0;
    for (int s = 0; s < NS; s++) begin
      int len;
      len = (s == 0) ? 1 : 8;
      for (int k = 0; k < len; k++) do_bit(s, k, k == len - 1, wsel);
    end
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rng = 32'h1d2c3b4a;
    m_hist = '0; m_snap = '0;
    for (int i = 0; i < NS; i++) begin m_act[i] = '0; m_shd[i] = '0; end
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_data = '0;
    slot_num = '0; slot_end = 1'b0; bit_stb = 1'b0;
    pcm_din = 1'b0; ins_din = 1'b0; pat_din = 1'b0;
    phase = "reset";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9: outputs idle after reset
    chk({5'd0, ch_wr}, 8'd0, "R9 ch_wr");
    chk({7'd0, ins_mark}, 8'd0, "R9 ins_mark");
    chk({7'd0, pat_en}, 8'd0, "R9 pat_en");
    // R9 reset table in use while R8 defers the first load
    phase = "R9 reset table, R8 load pending";
    run_frame(1);
    phase = "sweep table, R8 second load pending";
    run_frame(2);
    phase = "second table, R8 third load pending";
    run_frame(3);
    phase = "insert and repeat chains";
    run_frame(0);
    run_frame(0);
    // R10: no strobe, no write
    phase = "idle";
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); @(negedge clk);
      chk({5'd0, ch_wr}, 8'd0, "R10 idle ch_wr");
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule